// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges six reset requests into one system reset. The requests are power-on, low voltage on the core supply, low voltage on the I/O supply, wake-up from sleep, a long low level on the external reset pin, and a watchdog fault. It drives an open-drain style reset pin low while any request is present. After the last request clears, it keeps the pin low for a fixed stretch time. The same pin drive serves as the internal reset for neighbouring registers.

The block samples the pin level to detect reset requests from outside. A low level counts as an external request only when it outlasts a filter time. Detection is masked while the block pulls the pin low itself, and for one filter period after it lets go. This keeps its own drive from being logged as an external event.

Every cause is recorded in a sticky status register. That register survives the system reset and can be read over a small register port.

Top module: `rstc_top`

## Requirements
- R1: During and after the block reset `rst`, the pin pull, the system reset and the read data are all 0, and the status register reads 0x00.
- R2: The status register bits are: bit 0 power-on, bit 1 core-supply low voltage, bit 2 I/O-supply low voltage, bit 3 wake-up, bit 4 external, bit 5 watchdog. Bits 7:6 always read 0.
- R3: A power-on request clears every flag and leaves only bit 0 set (status 0x01) on the following cycle.
- R4: A flag, once set, stays set until the next power-on request, including while the system reset is asserted. Flags from different sources accumulate.
- R5: The pin pull (`pin_pull_o = 1`) and the system reset become 1 on the cycle after the first clock edge that samples a request.
- R6: After the last clock edge that samples a request, the pin pull stays 1 for exactly STRETCH_CYC further edges and drops at the next edge. A request held over several cycles restarts the stretch at each edge.
- R7: A wake-up event counts only in sleep mode (`mode_i` 2'b10). In run (2'b00) or stop (2'b01) it causes no reset and sets no flag.
- R8: With the block not masking, a pin low sampled at FILTER_CYC+1 consecutive edges raises an external request at the last of those edges. A low of FILTER_CYC edges or fewer has no effect.
- R9: External detection works in stop mode.
- R10: External detection is masked while the block pulls the pin and for FILTER_CYC edges after the pull is released. Counting of a pin that is still low starts only after that.
- R11: A read is `bus_en_i = 1` and `bus_we_i = 0` at address 0x15. It returns the zero-extended flags on the next cycle. Any other access returns 0 on the next cycle, and a write never changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_flag_i | input | 1 | Power-on comparator flag |
| lv_core_i | input | 1 | Core-supply low-voltage flag |
| lv_io_i | input | 1 | I/O-supply low-voltage flag |
| wake_evt_i | input | 1 | Wake-up event |
| wdog_fault_i | input | 1 | Watchdog fault |
| mode_i | input | 2 | Power mode: 00 run, 01 stop, 10 sleep, 11 treated as run |
| pin_lvl_i | input | 1 | Synchronized level of the reset pin |
| pin_pull_o | output | 1 | 1 pulls the reset pin low |
| sys_rst_o | output | 1 | Internal system reset, active high |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Access is a write (ignored) |
| bus_addr_i | input | 6 | Register address |
| bus_rdata_o | output | 8 | Read data, one cycle after the strobe |

## Verification
The assertions assume a few things about the inputs:
- The pin level arrives already synchronized to `clk`.
- Any low pin level the block causes shows up on `pin_lvl_i` in the same cycles as `pin_pull_o`, as it would on a wired-AND pin.
- FILTER_CYC is at least 1.

The bench keeps within these assumptions. It derives the pin level in the bench as the AND of the block's own pull and a separate external pull-down. It changes every request and the mode only at falling clock edges. Only with that pin model does the window after release test the masking, and not a glitch.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int CAUSE_N = 6;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_STOP  = 2'b01,
        MODE_SLEEP = 2'b10,
        MODE_RSVD  = 2'b11
    } pwr_mode_e;

    // Declared MSB first so that bit 0 is power-on and bit 5 is watchdog.
    typedef struct packed {
        logic wdog;
        logic ext;
        logic wake;
        logic lv_io;
        logic lv_core;
        logic pwr_on;
    } cause_t;

    function automatic logic any_cause(input cause_t c);
        return |c;
    endfunction

    function automatic logic [CAUSE_N-1:0] por_only();
        logic [CAUSE_N-1:0] v;
        v = '0;
        v[0] = 1'b1;
        return v;
    endfunction

    function automatic logic is_sleep(input logic [1:0] m);
        return pwr_mode_e'(m) == MODE_SLEEP;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILTER_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_lvl,
    input  logic self_drive,
    output logic ext_hit
);
    localparam int CW = $clog2(FILTER_CYC + 1);
    localparam logic [CW-1:0] FILT_MAX = CW'(FILTER_CYC);

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] mask_cnt;
    logic          masked;

    assign masked  = self_drive || (mask_cnt != '0);
    assign ext_hit = !pin_lvl && !masked && (low_cnt == FILT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            mask_cnt <= '0;
        end else begin
            if (self_drive)
                mask_cnt <= FILT_MAX;
            else if (mask_cnt != '0)
                mask_cnt <= mask_cnt - 1'b1;

            if (pin_lvl || masked)
                low_cnt <= '0;
            else if (low_cnt != FILT_MAX)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // A hit needs the pin seen low and unmasked on the previous edge too.
    p_low_run_r8: assert property (@(posedge clk) disable iff (rst)
        ext_hit |-> $past(!pin_lvl && !masked));

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic drive
);
    localparam int SW = $clog2(STRETCH_CYC + 1);
    localparam logic [SW-1:0] HOLD_MAX = SW'(STRETCH_CYC);

    logic [SW-1:0] hold_cnt;
    logic          drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            drive_q  <= 1'b0;
        end else begin
            drive_q <= req || (hold_cnt != '0);
            if (req)
                hold_cnt <= HOLD_MAX;
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign drive = drive_q;

    p_assert_on_req_r5: assert property (@(posedge clk) disable iff (rst)
        req |=> drive_q);

    p_release_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_q) |-> !$past(req));

endmodule

// File: rtl/rstc_cause_log.sv
module rstc_cause_log
    import rstc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  cause_t            hit,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - CAUSE_N;

    logic [CAUSE_N-1:0] hit_v;
    logic [CAUSE_N-1:0] flag_q;
    logic [DATA_W-1:0]  rd_q;
    logic               rd_sel;

    assign hit_v  = hit;
    assign rd_sel = bus_en && !bus_we && (bus_addr == STATUS_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else if (hit.pwr_on)
            flag_q <= por_only();
        else
            flag_q <= flag_q | hit_v;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_sel)
            rd_q <= {{PAD_W{1'b0}}, flag_q};
        else
            rd_q <= '0;
    end

    assign rd_data = rd_q;

    p_por_only_r3: assert property (@(posedge clk) disable iff (rst)
        hit.pwr_on |=> (flag_q == por_only()));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !hit.pwr_on |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_sel |=> (rd_q == '0));

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int FILTER_CYC  = 4,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_flag_i,
    input  logic              lv_core_i,
    input  logic              lv_io_i,
    input  logic              wake_evt_i,
    input  logic              wdog_fault_i,
    input  logic [1:0]        mode_i,
    input  logic              pin_lvl_i,
    output logic              pin_pull_o,
    output logic              sys_rst_o,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    cause_t hit;
    logic   ext_hit;
    logic   req_any;
    logic   pull;

    always_comb begin
        hit         = '0;
        hit.pwr_on  = por_flag_i;
        hit.lv_core = lv_core_i;
        hit.lv_io   = lv_io_i;
        hit.wake    = wake_evt_i && is_sleep(mode_i);
        hit.ext     = ext_hit;
        hit.wdog    = wdog_fault_i;
    end

    assign req_any = any_cause(hit);

    rstc_pin_filter #(.FILTER_CYC(FILTER_CYC)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .pin_lvl    (pin_lvl_i),
        .self_drive (pull),
        .ext_hit    (ext_hit)
    );

    rstc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk   (clk),
        .rst   (rst),
        .req   (req_any),
        .drive (pull)
    );

    rstc_cause_log #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_log (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .bus_en   (bus_en_i),
        .bus_we   (bus_we_i),
        .bus_addr (bus_addr_i),
        .rd_data  (bus_rdata_o)
    );

    assign pin_pull_o = pull;
    assign sys_rst_o  = pull;

    p_no_self_ext_r10: assert property (@(posedge clk) disable iff (rst)
        pull |-> !ext_hit);

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[DATA_W-1:CAUSE_N] == '0);

endmodule

// File: tb/test_rstc_top.sv
module test_rstc_top;

    localparam int STRETCH = 16;
    localparam int FILT    = 4;
    localparam logic [5:0] ST_ADDR = 6'h15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0, lvc = 1'b0, lvi = 1'b0, wake = 1'b0, wdog = 1'b0;
    logic [1:0] mode = 2'b00;
    logic ext_low = 1'b0;
    logic pin_lvl;
    logic pin_pull, sys_rst;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    assign pin_lvl = ~(pin_pull | ext_low);

    rstc_top #(.STRETCH_CYC(STRETCH), .FILTER_CYC(FILT)) i_rstc_top (
        .clk          (clk),
        .rst          (rst),
        .por_flag_i   (por),
        .lv_core_i    (lvc),
        .lv_io_i      (lvi),
        .wake_evt_i   (wake),
        .wdog_fault_i (wdog),
        .mode_i       (mode),
        .pin_lvl_i    (pin_lvl),
        .pin_pull_o   (pin_pull),
        .sys_rst_o    (sys_rst),
        .bus_en_i     (bus_en),
        .bus_we_i     (bus_we),
        .bus_addr_i   (bus_addr),
        .bus_rdata_o  (rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [5:0] addr, output logic [7:0] val);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = addr;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        val = rdata;
    endtask

    task automatic read_status(output logic [7:0] val);
        access(1'b0, ST_ADDR, val);
    endtask

    // Pulse one request for a single edge; leaves time at the negedge after it.
    task automatic pulse(input int which, input string tag);
        @(negedge clk);
        case (which)
            0: por = 1'b1;
            1: lvc = 1'b1;
            2: lvi = 1'b1;
            3: wake = 1'b1;
            default: wdog = 1'b1;
        endcase
        @(negedge clk);
        por = 1'b0; lvc = 1'b0; lvi = 1'b0; wake = 1'b0; wdog = 1'b0;
        check({tag, " pull one cycle after request"}, {31'b0, pin_pull}, 1);
        check({tag, " sys_rst one cycle after request"}, {31'b0, sys_rst}, 1);
    endtask

    task automatic check_stretch(input string tag);
        int bad = 0;
        for (int k = 1; k <= STRETCH; k++) begin
            @(negedge clk);
            if (pin_pull !== 1'b1 || sys_rst !== 1'b1) bad++;
        end
        check({tag, " cycles released early"}, bad, 0);
        @(negedge clk);
        check({tag, " release after stretch"}, {31'b0, pin_pull}, 0);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (pin_pull !== 1'b0 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (FILT + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 pull in reset", {31'b0, pin_pull}, 0);
        check("R1 sys_rst in reset", {31'b0, sys_rst}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", {24'b0, rdata}, 0);
        read_status(v);
        check("R1 status after reset", {24'b0, v}, 8'h00);
    endtask

    task automatic t_power_on();
        logic [7:0] v;
        pulse(0, "R5 por");
        check_stretch("R6 por");
        read_status(v);
        check("R3 status after por", {24'b0, v}, 8'h01);
        wait_idle();
    endtask

    task automatic t_watchdog();
        logic [7:0] v;
        pulse(4, "R5 wdog");
        check_stretch("R6 wdog");
        read_status(v);
        // The pin was held low well beyond the filter time, but only by the block.
        check("R10 R2 R4 status after wdog", {24'b0, v}, 8'h21);
        wait_idle();
    endtask

    task automatic t_low_voltage();
        logic [7:0] v;
        pulse(1, "R5 core lv");
        read_status(v);
        check("R4 flags readable during sys_rst", {31'b0, sys_rst}, 1);
        check("R2 R4 core lv bit1", {24'b0, v}, 8'h23);
        wait_idle();
        pulse(2, "R5 io lv");
        wait_idle();
        read_status(v);
        check("R2 io lv bit2", {24'b0, v}, 8'h27);
    endtask

    task automatic t_wake();
        logic [7:0] v;
        int seen = 0;
        mode = 2'b00;
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        repeat (3) begin @(negedge clk); if (pin_pull) seen++; end
        check("R7 wake in run no reset", seen, 0);
        mode = 2'b01;
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        repeat (3) begin @(negedge clk); if (pin_pull) seen++; end
        check("R7 wake in stop no reset", seen, 0);
        read_status(v);
        check("R7 wake outside sleep no flag", {24'b0, v}, 8'h27);
        mode = 2'b10;
        pulse(3, "R5 R7 wake in sleep");
        mode = 2'b00;
        wait_idle();
        read_status(v);
        check("R2 R7 wake bit3", {24'b0, v}, 8'h2F);
    endtask

    task automatic t_ext_short();
        logic [7:0] v;
        int seen = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (FILT) @(negedge clk);
        ext_low = 1'b0;
        repeat (4) begin @(negedge clk); if (pin_pull) seen++; end
        check("R8 low of filter length ignored", seen, 0);
        read_status(v);
        check("R8 no ext flag", {24'b0, v}, 8'h2F);
    endtask

    task automatic t_ext_stop();
        logic [7:0] v;
        int early = 0;
        mode = 2'b01;
        @(negedge clk); ext_low = 1'b1;
        for (int k = 1; k <= FILT; k++) begin
            @(negedge clk);
            if (pin_pull) early++;
        end
        check("R8 R9 no pull before filter expires", early, 0);
        @(negedge clk);
        ext_low = 1'b0;
        check("R8 R9 pull after filter+1 lows", {31'b0, pin_pull}, 1);
        check_stretch("R6 ext");
        mode = 2'b00;
        read_status(v);
        check("R2 R9 ext bit4", {24'b0, v}, 8'h3F);
        wait_idle();
    endtask

    task automatic t_mask_window();
        int early = 0;
        pulse(4, "R5 wdog mask");
        ext_low = 1'b1;
        check_stretch("R6 wdog mask");
        for (int k = 1; k <= 2 * FILT; k++) begin
            @(negedge clk);
            if (pin_pull) early++;
        end
        check("R10 masked window and count", early, 0);
        @(negedge clk);
        check("R10 ext counted after mask", {31'b0, pin_pull}, 1);
        ext_low = 1'b0;
        wait_idle();
    endtask

    task automatic t_bus();
        logic [7:0] v;
        access(1'b1, ST_ADDR, v);
        check("R11 write returns zero", {24'b0, v}, 0);
        access(1'b0, 6'h14, v);
        check("R11 other address zero", {24'b0, v}, 0);
        read_status(v);
        check("R11 write left flags", {24'b0, v}, 8'h3F);
    endtask

    task automatic t_por_hold();
        logic [7:0] v;
        @(negedge clk); por = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0;
        check("R5 pull during por hold", {31'b0, pin_pull}, 1);
        check_stretch("R6 held por");
        read_status(v);
        check("R3 por clears others", {24'b0, v}, 8'h01);
        wait_idle();
    endtask

    initial begin
        t_reset();
        t_power_on();
        t_watchdog();
        t_low_voltage();
        t_wake();
        t_ext_short();
        t_ext_stop();
        t_mask_window();
        t_bus();
        t_por_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule